// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the bus-facing register front end of an interrupt router. Software reaches the router's configuration through three 32-bit locations: an index register, a data window and a direct end-of-interrupt port. The index register picks one internal register: the router identifier, the version word, the arbitration word, or one half of a 64-bit per-pin routing entry. Reads and writes of the data window then act on that register.

The block holds the routing table. It keeps the two status bits of each entry under the control of the delivery engine, and lets a bus write change only the other bits. It reports every entry write to the engine on an update port. It raises a one-cycle request when a write changes an entry field that affects trigger-mode bookkeeping. It forwards every end-of-interrupt vector to the engine. Every bus request gets a registered response one cycle later. Any access that is not a full 32-bit access is refused with an error and has no effect.

Top module: `irq_window_regs`

## Requirements
- R1: After reset the index register and the identifier read 0. Every routing entry is 64'h0000_0000_0001_0000, which has only the mask bit (bit 16) set. rsp_valid, tmr_req, upd_valid and eoi_valid are low.
- R2: A request whose byte enables are not all four set (req_be != 4'hF) is answered with rsp_err=1 and rsp_rdata=0. It changes no state and causes no tmr_req, upd_valid or eoi_valid.
- R3: Each request is answered with rsp_valid one cycle later. The index register is at byte offset 0x00, the data window at 0x10 and the end-of-interrupt port at 0x40. Reads at any other offset return 0, and writes there change nothing. A write response carries rsp_rdata=0.
- R4: The index register keeps and reads back all 32 written bits, but only bits [7:0] select the window register.
- R5: Index 0 is the identifier. A write stores the data ANDed with 32'h0F00_0000. Index 2 (arbitration) reads the same identifier value. Writes to index 1 and index 2 are ignored.
- R6: Index 1 (version) reads ((PINS-1) << 16) | 32'h11.
- R7: Index 0x10+2*p reaches bits [31:0] of entry p, and index 0x10+2*p+1 reaches bits [63:32], for p from 0 to PINS-1.
- R8: A low-word write replaces every bit of [31:0] except remote-IRR (bit 14) and delivery status (bit 12), which keep their values. A high-word write replaces [63:32] in full.
- R9: tmr_req is high for one cycle, in the response cycle of an entry write, exactly when the write changed some entry bit other than mask (16) and polarity (13).
- R10: A write to offset 0x40 makes eoi_valid high for one cycle in the response cycle, with eoi_vector equal to bits [7:0] of the written data. A read there returns 0.
- R11: Window indices 3 to 0x0F and indices at or above 0x10+2*PINS read 0, and writes to them are ignored.
- R12: Every accepted entry write makes upd_valid high in the response cycle, with upd_pin equal to the pin and upd_entry equal to the full new 64-bit entry.
- R13: A sts_valid cycle loads sts_irr into bit 14 and sts_dlv into bit 12 of entry sts_pin. The new values are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the block |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after request |
| rsp_err | output | 1 | Request refused (not 32-bit) |
| rsp_rdata | output | 32 | Read data |
| sts_valid | input | 1 | Engine status update strobe |
| sts_pin | input | PW | Pin whose status bits are loaded |
| sts_irr | input | 1 | New remote-IRR value |
| sts_dlv | input | 1 | New delivery-status value |
| upd_valid | output | 1 | Entry was written by the bus |
| upd_pin | output | PW | Pin of the written entry |
| upd_entry | output | 64 | New entry value |
| tmr_req | output | 1 | Trigger-mode recalculation request |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | End-of-interrupt vector |

## Verification
The hardest case to reach from the bus alone is an entry whose protected status bits are set. A bus write can never set those bits, so only the engine-side status port can put an entry into that state. The stimulus therefore mixes random status-port updates with random low-word writes, so that preservation is checked with both zeros and ones in the protected bits. Directed writes that flip only the mask or polarity bit, together with writes that repeat the stored value, show that tmr_req stays low when nothing relevant changes.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  typedef enum logic [1:0] {OFF_SEL, OFF_WIN, OFF_EOI, OFF_NONE} off_t;
  typedef enum logic [2:0] {IX_ID, IX_VER, IX_ARB, IX_ENT, IX_NONE} idx_t;

  localparam int BIT_DLV  = 12;
  localparam int BIT_POL  = 13;
  localparam int BIT_IRR  = 14;
  localparam int BIT_MASK = 16;

  localparam logic [31:0] RO_LO      = 32'h0000_5000;
  localparam logic [63:0] TMR_IGNORE = 64'h0000_0000_0001_2000;
  localparam logic [63:0] ENT_RESET  = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irqw_decode.sv
module irqw_decode
  import irqw_pkg::*;
#(
  parameter int PINS = 24,
  parameter logic [7:0] SEL_OFF  = 8'h00,
  parameter logic [7:0] WIN_OFF  = 8'h10,
  parameter logic [7:0] EOI_OFF  = 8'h40,
  parameter logic [7:0] ENT_BASE = 8'h10,
  localparam int PW = $clog2(PINS)
) (
  input  logic [7:0]    addr,
  input  logic [7:0]    sel_idx,
  output off_t          off,
  output idx_t          kind,
  output logic [PW-1:0] pin,
  output logic          hi
);
  localparam logic [8:0] ENT_WORDS = 9'(2 * PINS);

  logic [8:0] rel;

  always_comb begin
    case (addr)
      SEL_OFF: off = OFF_SEL;
      WIN_OFF: off = OFF_WIN;
      EOI_OFF: off = OFF_EOI;
      default: off = OFF_NONE;
    endcase
  end

  always_comb begin
    rel = {1'b0, sel_idx} - {1'b0, ENT_BASE};
    pin = rel[PW:1];
    hi  = rel[0];
    if (sel_idx == 8'd0)      kind = IX_ID;
    else if (sel_idx == 8'd1) kind = IX_VER;
    else if (sel_idx == 8'd2) kind = IX_ARB;
    else if (sel_idx >= ENT_BASE && rel < ENT_WORDS) kind = IX_ENT;
    else kind = IX_NONE;
  end
endmodule

// File: rtl/irqw_table.sv
module irqw_table
  import irqw_pkg::*;
#(
  parameter int PINS = 24,
  localparam int PW = $clog2(PINS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [PW-1:0] wr_pin,
  input  logic [31:0]   wr_data,
  input  logic          st_en,
  input  logic [PW-1:0] st_pin,
  input  logic          st_irr,
  input  logic          st_dlv,
  input  logic [PW-1:0] rd_pin,
  input  logic          rd_hi,
  output logic [31:0]   rd_data,
  output logic [63:0]   new_ent,
  output logic [63:0]   chg
);
  logic [63:0] ent [PINS];
  logic [63:0] old_ent;

  always_comb begin
    old_ent = ent[wr_pin];
    if (wr_hi) new_ent = {wr_data, old_ent[31:0]};
    else       new_ent = {old_ent[63:32], (wr_data & ~RO_LO) | (old_ent[31:0] & RO_LO)};
    chg = old_ent ^ new_ent;
  end

  assign rd_data = rd_hi ? ent[rd_pin][63:32] : ent[rd_pin][31:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PINS; i++) ent[i] <= ENT_RESET;
    end else begin
      if (wr_en) ent[wr_pin] <= new_ent;
      if (st_en) begin
        ent[st_pin][BIT_IRR] <= st_irr;
        ent[st_pin][BIT_DLV] <= st_dlv;
      end
    end
  end

  // R8
  ro_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi && !(st_en && st_pin == wr_pin)) |=>
      ({ent[$past(wr_pin)][BIT_IRR], ent[$past(wr_pin)][BIT_DLV]} ==
       $past({ent[wr_pin][BIT_IRR], ent[wr_pin][BIT_DLV]})));

  // R13
  sts_load_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |=> (ent[$past(st_pin)][BIT_IRR] == $past(st_irr) &&
               ent[$past(st_pin)][BIT_DLV] == $past(st_dlv)));
endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
  import irqw_pkg::*;
#(
  parameter int PINS = 24,
  parameter logic [31:0] ID_MASK = 32'h0F00_0000,
  localparam int PW = $clog2(PINS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [7:0]    req_addr,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata,
  input  logic          sts_valid,
  input  logic [PW-1:0] sts_pin,
  input  logic          sts_irr,
  input  logic          sts_dlv,
  output logic          upd_valid,
  output logic [PW-1:0] upd_pin,
  output logic [63:0]   upd_entry,
  output logic          tmr_req,
  output logic          eoi_valid,
  output logic [7:0]    eoi_vector
);
  localparam logic [31:0] VER_WORD = (32'(PINS - 1) << 16) | 32'h11;

  logic [31:0]   sel_q, id_q;
  off_t          off;
  idx_t          kind;
  logic [PW-1:0] e_pin;
  logic          e_hi;
  logic          acc, wr, rd, ent_we;
  logic [31:0]   tbl_rd, rd_mux;
  logic [63:0]   new_ent, chg;

  irqw_decode #(.PINS(PINS)) u_dec (
    .addr(req_addr), .sel_idx(sel_q[7:0]),
    .off(off), .kind(kind), .pin(e_pin), .hi(e_hi)
  );

  assign acc    = req_valid && (req_be == 4'hF);
  assign wr     = acc && req_write;
  assign rd     = acc && !req_write;
  assign ent_we = wr && off == OFF_WIN && kind == IX_ENT;

  irqw_table #(.PINS(PINS)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(ent_we), .wr_hi(e_hi), .wr_pin(e_pin), .wr_data(req_wdata),
    .st_en(sts_valid), .st_pin(sts_pin), .st_irr(sts_irr), .st_dlv(sts_dlv),
    .rd_pin(e_pin), .rd_hi(e_hi), .rd_data(tbl_rd),
    .new_ent(new_ent), .chg(chg)
  );

  always_comb begin
    rd_mux = '0;
    if (off == OFF_SEL) rd_mux = sel_q;
    else if (off == OFF_WIN) begin
      case (kind)
        IX_ID, IX_ARB: rd_mux = id_q;
        IX_VER:        rd_mux = VER_WORD;
        IX_ENT:        rd_mux = tbl_rd;
        default:       rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      id_q       <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      upd_valid  <= 1'b0;
      upd_pin    <= '0;
      upd_entry  <= '0;
      tmr_req    <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && (req_be != 4'hF);
      rsp_rdata <= rd ? rd_mux : '0;
      if (wr && off == OFF_SEL) sel_q <= req_wdata;
      if (wr && off == OFF_WIN && kind == IX_ID) id_q <= req_wdata & ID_MASK;
      upd_valid <= ent_we;
      if (ent_we) begin
        upd_pin   <= e_pin;
        upd_entry <= new_ent;
      end
      tmr_req   <= ent_we && |(chg & ~TMR_IGNORE);
      eoi_valid <= wr && off == OFF_EOI;
      if (wr && off == OFF_EOI) eoi_vector <= req_wdata[7:0];
    end
  end

  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_be != 4'hF) |=>
      (rsp_err && rsp_rdata == 32'd0 && !tmr_req && !upd_valid && !eoi_valid));

  // R9
  tmr_with_upd_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_req |-> upd_valid);

  // R10
  eoi_ok_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> (rsp_valid && !rsp_err));

  // R12
  upd_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (rsp_valid && !rsp_err));
endmodule

// File: tb/sim_irq_window_regs.sv
module sim_irq_window_regs;
  localparam int PINS = 24;
  localparam int PW = $clog2(PINS);
  localparam logic [31:0] IDM = 32'h0F00_0000;
  localparam logic [31:0] VER = (32'(PINS - 1) << 16) | 32'h11;
  localparam logic [31:0] RO  = 32'h0000_5000;
  localparam logic [63:0] IGN = 64'h0000_0000_0001_2000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [3:0] req_be = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic sts_valid = 0, sts_irr = 0, sts_dlv = 0;
  logic [PW-1:0] sts_pin = 0;
  logic upd_valid, tmr_req, eoi_valid;
  logic [PW-1:0] upd_pin;
  logic [63:0] upd_entry;
  logic [7:0] eoi_vector;

  int checks = 0, errors = 0;
  logic [63:0] m_ent [PINS];
  logic [31:0] m_sel, m_id;

  always #4 clk = ~clk;

  irq_window_regs #(.PINS(PINS)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] win_rd(input logic [7:0] ix);
    int r;
    if (ix == 0 || ix == 2) return m_id;
    if (ix == 1) return VER;
    r = int'(ix) - 16;
    if (ix >= 16 && r < 2 * PINS)
      return r[0] ? m_ent[r / 2][63:32] : m_ent[r / 2][31:0];
    return 32'd0;
  endfunction

  task automatic xact(input bit w, input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    bit acc, e_upd, e_tmr, e_eoi;
    logic [31:0] e_rd;
    logic [63:0] oldv, newv;
    int r, p;
    acc = (be == 4'hF);
    e_rd = 0; e_upd = 0; e_tmr = 0; e_eoi = 0; p = 0; newv = 0;
    if (acc && !w) begin
      if (a == 8'h00) e_rd = m_sel;
      else if (a == 8'h10) e_rd = win_rd(m_sel[7:0]);
    end
    if (acc && w) begin
      if (a == 8'h00) m_sel = d;
      else if (a == 8'h40) e_eoi = 1;
      else if (a == 8'h10) begin
        r = int'(m_sel[7:0]) - 16;
        if (m_sel[7:0] == 0) m_id = d & IDM;
        else if (m_sel[7:0] >= 16 && r < 2 * PINS) begin
          p = r / 2;
          oldv = m_ent[p];
          newv = r[0] ? {d, oldv[31:0]} : {oldv[63:32], (d & ~RO) | (oldv[31:0] & RO)};
          m_ent[p] = newv;
          e_upd = 1;
          e_tmr = |((oldv ^ newv) & ~IGN);
        end
      end
    end
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1, "R3 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_err == !acc, "R2 rsp_err", 64'(rsp_err), 64'(!acc));
    chk(rsp_rdata == e_rd, "R7/R5/R11 rdata", 64'(rsp_rdata), 64'(e_rd));
    chk(upd_valid == e_upd, "R12 upd_valid", 64'(upd_valid), 64'(e_upd));
    if (e_upd) chk(upd_entry == newv && upd_pin == PW'(p), "R8 upd_entry", upd_entry, newv);
    chk(tmr_req == e_tmr, "R9 tmr_req", 64'(tmr_req), 64'(e_tmr));
    chk(eoi_valid == e_eoi, "R10 eoi_valid", 64'(eoi_valid), 64'(e_eoi));
    if (e_eoi) chk(eoi_vector == d[7:0], "R10 eoi_vector", 64'(eoi_vector), 64'(d[7:0]));
  endtask

  task automatic sts(input int p, input bit irr, input bit dlv);
    @(negedge clk);
    sts_valid = 1; sts_pin = PW'(p); sts_irr = irr; sts_dlv = dlv;
    @(negedge clk);
    sts_valid = 0;
    m_ent[p][14] = irr;
    m_ent[p][12] = dlv;
  endtask

  function automatic logic [7:0] pick_idx();
    case ($urandom % 4)
      0: return 8'($urandom % 3);
      1, 2: return 8'(16 + $urandom % (2 * PINS));
      default: return 8'($urandom % 256);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < PINS; i++) m_ent[i] = 64'h0000_0000_0001_0000;
    m_sel = 0; m_id = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(!rsp_valid && !tmr_req && !upd_valid && !eoi_valid, "R1 idle", 64'(tmr_req), 64'd0);
    xact(0, 8'h00, 4'hF, 0);
    xact(0, 8'h10, 4'hF, 0);
    // R6 version
    xact(1, 8'h00, 4'hF, 32'hABCD_EF01);
    xact(0, 8'h10, 4'hF, 0);
    // R4 high bits kept, index from low byte; R1 entry reset
    xact(1, 8'h00, 4'hF, 32'h5A5A_0010);
    xact(0, 8'h00, 4'hF, 0);
    xact(0, 8'h10, 4'hF, 0);
    // R2 bad size has no effect
    xact(1, 8'h00, 4'h3, 32'h0000_0002);
    xact(0, 8'h00, 4'hF, 0);
    xact(0, 8'h10, 4'h1, 0);
    // R5 ID masked, arbitration mirrors, ver/arb write ignored
    xact(1, 8'h00, 4'hF, 0);
    xact(1, 8'h10, 4'hF, 32'hFFFF_FFFF);
    xact(1, 8'h00, 4'hF, 2);
    xact(1, 8'h10, 4'hF, 32'h1234_5678);
    xact(0, 8'h10, 4'hF, 0);
    xact(1, 8'h00, 4'hF, 1);
    xact(1, 8'h10, 4'hF, 0);
    xact(0, 8'h10, 4'hF, 0);
    // R3 other offsets
    xact(0, 8'h20, 4'hF, 0);
    xact(1, 8'h24, 4'hF, 32'hFFFF_FFFF);
    // R8/R13 status bits kept on low write
    sts(3, 1, 1);
    xact(1, 8'h00, 4'hF, 32'h16);
    xact(1, 8'h10, 4'hF, 32'h0000_0000);
    xact(0, 8'h10, 4'hF, 0);
    // R9 mask-only, polarity-only and identical writes: no tmr
    xact(1, 8'h10, 4'hF, 32'h0001_0000);
    xact(1, 8'h10, 4'hF, 32'h0001_2000);
    xact(1, 8'h10, 4'hF, 32'h0001_2000);
    xact(1, 8'h10, 4'hF, 32'h0001_A000);
    // R7 last high word and first index past the table (R11)
    xact(1, 8'h00, 4'hF, 32'(16 + 2 * PINS - 1));
    xact(1, 8'h10, 4'hF, 32'hFF00_0000);
    xact(0, 8'h10, 4'hF, 0);
    xact(1, 8'h00, 4'hF, 32'(16 + 2 * PINS));
    xact(1, 8'h10, 4'hF, 32'hDEAD_BEEF);
    xact(0, 8'h10, 4'hF, 0);
    xact(1, 8'h00, 4'hF, 5);
    xact(1, 8'h10, 4'hF, 32'hDEAD_BEEF);
    xact(0, 8'h10, 4'hF, 0);
    // R10 EOI
    xact(1, 8'h40, 4'hF, 32'h0000_1231);
    xact(0, 8'h40, 4'hF, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0: xact($urandom % 2 == 0, 8'($urandom % 256), 4'($urandom % 15), $urandom);
        1: xact(1, 8'h00, 4'hF, {24'($urandom), pick_idx()});
        2, 3: xact(1, 8'h10, 4'hF, $urandom);
        4: xact(1, 8'h10, 4'hF, win_rd(m_sel[7:0]) ^ (($urandom % 2 == 0) ? 32'h0001_0000 : 32'h0000_2000));
        5, 6: xact(0, 8'h10, 4'hF, 0);
        7: xact(1, 8'h40, 4'hF, $urandom);
        8: sts(int'($urandom % PINS), $urandom % 2 == 1, $urandom % 2 == 1);
        default: xact($urandom % 2 == 0, 8'(($urandom % 64) * 4), 4'hF, $urandom);
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule